// File: doc/BRIEF.md
# Floating-point register immediate-load sequencer

This unit takes a single 32-bit load-immediate instruction word for the floating-point register file. It decodes the word and forms a byte address from a base value and a scaled 8-bit immediate, which is either added or subtracted. It then issues one or two word reads on a synchronous memory port with a one-cycle read latency. The returned data is assembled into a single 16-bit, 32-bit or 64-bit result, which leaves the unit on a register-file write port. The core pipeline presents an instruction word together with the current value of the base general-purpose register and the current PC. The unit is busy until it pulses `done`, or until it pulses `undef` when it rejects the word.

A double-width load uses two memory beats. The first beat reads the effective address and the second reads the effective address plus four. The two words are joined in an order set by the endianness input. A half-width load zero-extends the fetched halfword into a 32-bit single register. When the base field selects register 15, the unit uses the PC with its two low bits cleared as the base.

Top module: `fp_imm_load_unit`

## Requirements
- R1: A word is recognised when bits 27:25 are 110, bit 24 is 1, bit 21 is 0, bit 20 is 1 and bits 11:10 are 10. Bits 31:28 are free, so a word whose top seven bits are 1110110 also matches. Any other word raises `undef`.
- R2: Bits 9:8 select the size: 01 is a halfword load, 10 is a word load, 11 is a doubleword load. The value 00 raises `undef`.
- R3: The 8-bit immediate in bits 7:0 is zero-extended and shifted left by two for word and doubleword loads, and by one for halfword loads.
- R4: When bit 23 is 1, the address is base plus offset. When bit 23 is 0, it is base minus offset.
- R5: When bits 19:16 equal 15, the base is `pc_value` with bits 1:0 cleared, and `base_value` is ignored.
- R6: A halfword load writes the low 16 bits of the returned word. Bits 63:16 of `rf_wr_data` are zero.
- R7: A doubleword load reads address A, then A+4. With `big_endian`=1 the result is {word at A, word at A+4}. With `big_endian`=0 it is {word at A+4, word at A}.
- R8: The destination index is {bits 15:12, bit 22} for single loads and {bit 22, bits 15:12} for double loads. A double index of 16 or more raises `undef`.
- R9: With `fpu_enable`=0, the unit raises `undef` and makes no memory request and no register write.
- R10: A halfword load with an odd effective address raises `undef` and makes no memory access.
- R11: If a word is accepted at edge E0, the first read request is driven in the cycle after E0. Read data is sampled one cycle after each request. The write happens in the cycle after the last data beat, and `done` pulses in the cycle after the write.
- R12: `instr_valid` is accepted only while the unit is idle. A strobe during a sequence has no effect.
- R13: `undef` is a one-cycle pulse in the cycle after acceptance, and `done` does not follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 32 | Load instruction word |
| base_value | input | AW | Value of the selected base register |
| pc_value | input | AW | Current PC |
| big_endian | input | 1 | Word order for double loads |
| fpu_enable | input | 1 | Floating-point unit enabled |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read byte address |
| mem_rd_data | input | DW | Read data, one cycle after request |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 5 | Destination register index |
| rf_wr_data | output | 2*DW | Assembled write data |
| rf_wr_dbl | output | 1 | Write targets a double register |
| done | output | 1 | Load complete pulse |
| undef | output | 1 | Undefined-instruction pulse |

## Verification
The bench targets the subtract direction, a PC base with unaligned low bits, an odd halfword address, both double-word orders, a double destination above 15, a disabled unit and a strobe arriving mid-sequence. A design that ignored the U bit would read from a mirrored address. One that used the raw PC would be off by the low bits. One that swapped beat order would return the two words exchanged for one endianness. One that accepted a strobe while busy would issue extra reads and writes. Reserved sizes and broken opcode fields must give a lone `undef` pulse with no traffic, and a per-cycle reference model catches any beat that lands a cycle early or late.

// File: rtl/fpld_pkg.sv
package fpld_pkg;

   typedef enum logic [1:0] {
      SZ_RSVD = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_DBL  = 2'b11
   } fpld_size_e;

   typedef struct packed {
      logic       match;
      fpld_size_e size;
      logic       up;
      logic       dbit;
      logic [3:0] rn;
      logic [3:0] vd;
      logic [7:0] imm8;
   } fpld_dec_t;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ   = 3'd1,
      ST_BEAT1 = 3'd2,
      ST_BEAT2 = 3'd3,
      ST_WRITE = 3'd4,
      ST_DONE  = 3'd5,
      ST_UNDEF = 3'd6
   } fpld_state_e;

   localparam logic [3:0] PC_BASE_IDX = 4'hF;
   localparam int         IW          = 32;

endpackage

// File: rtl/fpld_decode.sv
module fpld_decode
   import fpld_pkg::*;
#(
   parameter bit T32_ONLY = 1'b0
) (
   input  logic [IW-1:0] word,
   output fpld_dec_t     dec
);
   localparam logic RELAX_TOP = !T32_ONLY;

   logic fields_ok;
   logic top_is_t32;
   logic top_ok;

   assign fields_ok  = (word[27:25] == 3'b110) && word[24] && !word[21] &&
                       word[20] && (word[11:10] == 2'b10);
   assign top_is_t32 = (word[31:25] == 7'b1110110);
   assign top_ok     = top_is_t32 | RELAX_TOP;

   always_comb begin
      dec.match = fields_ok & top_ok;
      dec.size  = fpld_size_e'(word[9:8]);
      dec.up    = word[23];
      dec.dbit  = word[22];
      dec.rn    = word[19:16];
      dec.vd    = word[15:12];
      dec.imm8  = word[7:0];
   end

endmodule

// File: rtl/fpld_addr_gen.sv
module fpld_addr_gen
   import fpld_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] base_value,
   input  logic [AW-1:0] pc_value,
   input  logic [3:0]    rn,
   input  logic [7:0]    imm8,
   input  logic          up,
   input  logic          half,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] ea_next,
   output logic          misaligned
);
   localparam int OFF_W = 10;

   generate
      if (AW < OFF_W + 2) begin : g_bad_aw
         $error("fpld_addr_gen: AW too small for scaled offset");
      end
   endgenerate

   logic [OFF_W-1:0] off_small;
   logic [AW-1:0]    offset;
   logic [AW-1:0]    base_sel;

   assign off_small  = half ? {1'b0, imm8, 1'b0} : {imm8, 2'b00};
   assign offset     = AW'(off_small);
   assign base_sel   = (rn == PC_BASE_IDX) ? (pc_value & ~AW'(3)) : base_value;
   assign ea         = up ? (base_sel + offset) : (base_sel - offset);
   assign ea_next    = ea + AW'(4);
   assign misaligned = half & ea[0];

endmodule

// File: rtl/fpld_beat_asm.sv
module fpld_beat_asm
   import fpld_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cap,
   input  logic            big_end,
   input  fpld_size_e      size,
   input  logic [DW-1:0]   rd_data,
   output logic [2*DW-1:0] wr_data
);
   localparam int HW = DW / 2;

   generate
      if (DW != 32) begin : g_bad_dw
         $error("fpld_beat_asm: only 32-bit words are supported");
      end
   endgenerate

   logic [DW-1:0] beat_q [2];

   for (genvar b = 0; b < 2; b++) begin : g_beat
      always_ff @(posedge clk) begin
         if (!rst_n)
            beat_q[b] <= '0;
         else if (cap[b])
            beat_q[b] <= rd_data;
      end
   end

   always_comb begin
      unique case (size)
         SZ_HALF: wr_data = {{(2*DW-HW){1'b0}}, beat_q[0][HW-1:0]};
         SZ_DBL:  wr_data = big_end ? {beat_q[0], beat_q[1]}
                                    : {beat_q[1], beat_q[0]};
         default: wr_data = {{DW{1'b0}}, beat_q[0]};
      endcase
   end

endmodule

// File: rtl/fp_imm_load_unit.sv
module fp_imm_load_unit
   import fpld_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int NUM_DREGS = 16,
   parameter bit T32_ONLY  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [31:0]     instr_word,
   input  logic [AW-1:0]   base_value,
   input  logic [AW-1:0]   pc_value,
   input  logic            big_endian,
   input  logic            fpu_enable,
   output logic            mem_rd_en,
   output logic [AW-1:0]   mem_rd_addr,
   input  logic [DW-1:0]   mem_rd_data,
   output logic            rf_wr_en,
   output logic [4:0]      rf_wr_idx,
   output logic [2*DW-1:0] rf_wr_data,
   output logic            rf_wr_dbl,
   output logic            done,
   output logic            undef
);
   localparam int SREG_CNT = 2 * NUM_DREGS;

   generate
      if (NUM_DREGS < 1 || NUM_DREGS > 16) begin : g_bad_regs
         $error("fp_imm_load_unit: NUM_DREGS must be 1..16");
      end
   endgenerate

   fpld_dec_t   dec;
   fpld_state_e state_q, state_d;
   fpld_size_e  size_q;
   logic        big_q;
   logic [4:0]  idx_q;
   logic [AW-1:0] ea_q, ea2_q;
   logic [AW-1:0] ea, ea_next;
   logic        misaligned;
   logic [4:0]  sgl_idx, dbl_idx;
   logic        is_dbl, idx_ok, bad, accept;

   fpld_decode #(.T32_ONLY(T32_ONLY)) i_dec (
      .word (instr_word),
      .dec  (dec)
   );

   fpld_addr_gen #(.AW(AW)) i_agen (
      .base_value (base_value),
      .pc_value   (pc_value),
      .rn         (dec.rn),
      .imm8       (dec.imm8),
      .up         (dec.up),
      .half       (dec.size == SZ_HALF),
      .ea         (ea),
      .ea_next    (ea_next),
      .misaligned (misaligned)
   );

   assign sgl_idx = {dec.vd, dec.dbit};
   assign dbl_idx = {dec.dbit, dec.vd};
   assign is_dbl  = (dec.size == SZ_DBL);
   assign idx_ok  = is_dbl ? (int'(dbl_idx) < NUM_DREGS)
                           : (int'(sgl_idx) < SREG_CNT);
   assign bad     = !fpu_enable || !dec.match || (dec.size == SZ_RSVD) ||
                    misaligned || !idx_ok;
   assign accept  = (state_q == ST_IDLE) && instr_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (instr_valid) state_d = bad ? ST_UNDEF : ST_REQ;
         ST_REQ:   state_d = ST_BEAT1;
         ST_BEAT1: state_d = (size_q == SZ_DBL) ? ST_BEAT2 : ST_WRITE;
         ST_BEAT2: state_d = ST_WRITE;
         ST_WRITE: state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         ST_UNDEF: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         size_q  <= SZ_RSVD;
         big_q   <= 1'b0;
         idx_q   <= '0;
         ea_q    <= '0;
         ea2_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            size_q <= dec.size;
            big_q  <= big_endian;
            idx_q  <= is_dbl ? dbl_idx : sgl_idx;
            ea_q   <= ea;
            ea2_q  <= ea_next;
         end
      end
   end

   fpld_beat_asm #(.DW(DW)) i_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     ({state_q == ST_BEAT2, state_q == ST_BEAT1}),
      .big_end (big_q),
      .size    (size_q),
      .rd_data (mem_rd_data),
      .wr_data (rf_wr_data)
   );

   assign mem_rd_en   = (state_q == ST_REQ) ||
                        ((state_q == ST_BEAT1) && (size_q == SZ_DBL));
   assign mem_rd_addr = (state_q == ST_BEAT1) ? ea2_q : ea_q;
   assign rf_wr_en    = (state_q == ST_WRITE);
   assign rf_wr_dbl   = (state_q == ST_WRITE) && (size_q == SZ_DBL);
   assign rf_wr_idx   = idx_q;
   assign done        = (state_q == ST_DONE);
   assign undef       = (state_q == ST_UNDEF);

   AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rf_wr_en)); // R11
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_en, rf_wr_en, done, undef})); // R11
   AST_SECOND_BEAT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + AW'(4))); // R7
   AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr_en && !rf_wr_dbl) |-> (rf_wr_data[2*DW-1:DW] == '0)); // R6
   AST_DBL_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr_en && rf_wr_dbl) |-> (int'(rf_wr_idx) < NUM_DREGS)); // R8
   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && instr_valid && !fpu_enable) |=> (undef && !mem_rd_en)); // R9
   AST_UNDEF_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      undef |-> $past(instr_valid)); // R13

endmodule

// File: tb/test_fp_imm_load_unit.sv
`timescale 1ns/1ps
module test_fp_imm_load_unit;

   typedef struct packed {
      logic        busy;
      logic        mem_en;
      logic [31:0] addr;
      logic        wr_en;
      logic [4:0]  idx;
      logic [63:0] data;
      logic        dbl;
      logic        done;
      logic        undef;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic [31:0] base_value = '0;
   logic [31:0] pc_value = '0;
   logic        big_endian = 1'b0;
   logic        fpu_enable = 1'b1;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [31:0] mem_rd_data = '0;
   logic        rf_wr_en;
   logic [4:0]  rf_wr_idx;
   logic [63:0] rf_wr_data;
   logic        rf_wr_dbl;
   logic        done;
   logic        undef;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   exp_t q[$];
   exp_t cur = '0;

   int          cnt_mem, cnt_wr, cnt_done, cnt_undef, cyc;
   int          mem_cyc, wr_cyc, done_cyc;
   logic [31:0] first_addr;
   logic [63:0] last_data;
   logic [4:0]  last_idx;
   logic        last_dbl;

   always #2.5 clk = ~clk;

   fp_imm_load_unit i_fp_imm_load_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .base_value(base_value), .pc_value(pc_value), .big_endian(big_endian),
      .fpu_enable(fpu_enable), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
      .rf_wr_data(rf_wr_data), .rf_wr_dbl(rf_wr_dbl), .done(done), .undef(undef)
   );

   function automatic logic [31:0] memf(input logic [31:0] a);
      return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
   endfunction

   function automatic logic [31:0] enc(input logic [3:0] cond, input logic u, input logic d,
                                       input logic [3:0] rn, input logic [3:0] vd,
                                       input logic [1:0] sz, input logic [7:0] imm);
      return {cond, 3'b110, 1'b1, u, d, 1'b0, 1'b1, rn, vd, 2'b10, sz, imm};
   endfunction

   // Reference: builds the per-cycle output sequence of one accepted word
   function automatic void plan(input logic [31:0] w, input logic [31:0] base,
                                input logic [31:0] pc, input logic be, input logic en);
      exp_t e;
      logic [1:0]  sz;
      logic [31:0] b, ea, w1, w2;
      int          off;
      logic        dbl, fields_ok, bad;
      sz        = w[9:8];
      fields_ok = (w[27:25] == 3'b110) && w[24] && !w[21] && w[20] && (w[11:10] == 2'b10);
      off       = (sz == 2'b01) ? int'(w[7:0]) * 2 : int'(w[7:0]) * 4;
      b         = (w[19:16] == 4'hF) ? {pc[31:2], 2'b00} : base;
      ea        = w[23] ? b + 32'(off) : b - 32'(off);
      dbl       = (sz == 2'b11);
      bad       = !en || !fields_ok || (sz == 2'b00) || ((sz == 2'b01) && ea[0]) || (dbl && w[22]);
      e = '0; e.busy = 1'b1;
      if (bad) begin
         e.undef = 1'b1; q.push_back(e); return;
      end
      w1 = memf(ea); w2 = memf(ea + 32'd4);
      e.mem_en = 1'b1; e.addr = ea; q.push_back(e);
      e = '0; e.busy = 1'b1;
      if (dbl) begin e.mem_en = 1'b1; e.addr = ea + 32'd4; end
      q.push_back(e);
      e = '0; e.busy = 1'b1;
      if (dbl) q.push_back(e);
      e.wr_en = 1'b1;
      e.dbl   = dbl;
      e.idx   = dbl ? {w[22], w[15:12]} : {w[15:12], w[22]};
      if (sz == 2'b01)      e.data = {48'b0, w1[15:0]};
      else if (sz == 2'b10) e.data = {32'b0, w1};
      else                  e.data = be ? {w1, w2} : {w2, w1};
      q.push_back(e);
      e = '0; e.busy = 1'b1; e.done = 1'b1; q.push_back(e);
   endfunction

   // Memory with one-cycle read latency
   always @(posedge clk)
      mem_rd_data <= mem_rd_en ? memf(mem_rd_addr) : 32'h0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); cur = '0;
      end else begin
         if (instr_valid && !cur.busy && q.size() == 0)
            plan(instr_word, base_value, pc_value, big_endian, fpu_enable);
         if (q.size() != 0) cur = q.pop_front();
         else cur = '0;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (mem_rd_en) begin
            if (cnt_mem == 0) begin first_addr <= mem_rd_addr; mem_cyc <= cyc; end
            cnt_mem <= cnt_mem + 1;
         end
         if (rf_wr_en) begin
            cnt_wr <= cnt_wr + 1; last_data <= rf_wr_data;
            last_idx <= rf_wr_idx; last_dbl <= rf_wr_dbl; wr_cyc <= cyc;
         end
         if (done)  begin cnt_done <= cnt_done + 1; done_cyc <= cyc; end
         if (undef) cnt_undef <= cnt_undef + 1;
      end
   end

   // Per-cycle comparison against the reference (R11)
   always @(negedge clk) begin
      exp_t a, x;
      if (rst_n && !finished) begin
         a = '0; x = cur; x.busy = 1'b0;
         a.mem_en = mem_rd_en; a.addr = mem_rd_en ? mem_rd_addr : 32'h0;
         a.wr_en = rf_wr_en;
         if (rf_wr_en) begin a.idx = rf_wr_idx; a.data = rf_wr_data; a.dbl = rf_wr_dbl; end
         a.done = done; a.undef = undef;
         checks++;
         if (a != x) begin
            fails++;
            $display("FAIL R11 cycle model act=%h exp=%h", a, x);
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [31:0] w, input logic [31:0] base, input logic [31:0] pc,
                      input logic be, input logic en, input bit extra);
      @(negedge clk);
      cnt_mem = 0; cnt_wr = 0; cnt_done = 0; cnt_undef = 0;
      first_addr = '0; last_data = '0; last_idx = '0; last_dbl = 1'b0;
      instr_word = w; base_value = base; pc_value = pc; big_endian = be; fpu_enable = en;
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      if (extra) begin
         @(negedge clk);
         instr_word = enc(4'hE, 1, 0, 4'd1, 4'd1, 2'b10, 8'd9);
         base_value = 32'h7700; instr_valid = 1'b1;
         @(negedge clk);
         instr_valid = 1'b0;
      end
      repeat (8) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      cyc = 0; cnt_mem = 0; cnt_wr = 0; cnt_done = 0; cnt_undef = 0;
      mem_cyc = 0; wr_cyc = 0; done_cyc = 0;
      repeat (4) @(negedge clk);
      chk("R11 reset outputs", {58'b0, mem_rd_en, rf_wr_en, done, undef, rf_wr_dbl, 1'b0}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R4 R8: word load, add, single index {Vd,D}
      run(enc(4'hE, 1, 1, 4'd3, 4'd2, 2'b10, 8'd5), 32'h1000, 32'h0, 0, 1, 0);
      chk("R4 add address", first_addr, 32'h1014);
      chk("R8 single index", last_idx, 5'd5);
      chk("R3 word data", last_data, {32'b0, memf(32'h1014)});
      chk("R11 write-to-done gap", done_cyc - wr_cyc, 1);
      chk("R11 request-to-write gap", wr_cyc - mem_cyc, 2);

      // R4 subtract
      run(enc(4'hE, 0, 0, 4'd3, 4'd2, 2'b10, 8'd5), 32'h1000, 32'h0, 0, 1, 0);
      chk("R4 subtract address", first_addr, 32'h0FEC);

      // R5 PC base with low bits cleared
      run(enc(4'hE, 1, 0, 4'hF, 4'd0, 2'b10, 8'd1), 32'hFFFF0000, 32'h2003, 0, 1, 0);
      chk("R5 pc base address", first_addr, 32'h2004);

      // R3 R6 halfword: offset <<1, zero extension
      run(enc(4'hE, 1, 0, 4'd2, 4'd7, 2'b01, 8'd3), 32'h3002, 32'h0, 0, 1, 0);
      chk("R3 half offset", first_addr, 32'h3008);
      chk("R6 half zero-extend", last_data, {48'b0, memf(32'h3008)[15:0]});

      // R10 odd halfword address
      run(enc(4'hE, 1, 0, 4'd2, 4'd7, 2'b01, 8'd2), 32'h3001, 32'h0, 0, 1, 0);
      chk("R10 misaligned undef", cnt_undef, 1);
      chk("R10 misaligned no access", cnt_mem, 0);

      // R7 double, little-endian
      run(enc(4'hE, 1, 0, 4'd4, 4'd4, 2'b11, 8'd2), 32'h4000, 32'h0, 0, 1, 0);
      chk("R7 two beats", cnt_mem, 2);
      chk("R7 little order", last_data, {memf(32'h400C), memf(32'h4008)});
      chk("R8 double index", {last_dbl, last_idx}, {1'b1, 5'd4});

      // R7 double, big-endian
      run(enc(4'hE, 1, 0, 4'd4, 4'd9, 2'b11, 8'd2), 32'h4000, 32'h0, 1, 1, 0);
      chk("R7 big order", last_data, {memf(32'h4008), memf(32'h400C)});

      // R8 double index >= 16 rejected; single index 31 allowed
      run(enc(4'hE, 1, 1, 4'd4, 4'd3, 2'b11, 8'd0), 32'h4000, 32'h0, 0, 1, 0);
      chk("R8 double high undef", cnt_undef, 1);
      run(enc(4'hE, 1, 1, 4'd4, 4'hF, 2'b10, 8'd0), 32'h4000, 32'h0, 0, 1, 0);
      chk("R8 single index 31", last_idx, 5'd31);

      // R9 R13 disabled unit
      run(enc(4'hE, 1, 0, 4'd1, 4'd1, 2'b10, 8'd1), 32'h5000, 32'h0, 0, 0, 0);
      chk("R9 disabled no access", cnt_mem + cnt_wr, 0);
      chk("R13 single undef pulse", cnt_undef, 1);
      chk("R13 no done after undef", cnt_done, 0);

      // R2 reserved size
      run(enc(4'hE, 1, 0, 4'd1, 4'd1, 2'b00, 8'd1), 32'h5000, 32'h0, 0, 1, 0);
      chk("R2 reserved size undef", cnt_undef, 1);

      // R1 broken opcode field and free condition bits
      run(enc(4'hE, 1, 0, 4'd1, 4'd1, 2'b10, 8'd1) | 32'h0020_0000, 32'h5000, 32'h0, 0, 1, 0);
      chk("R1 bit21 set undef", cnt_undef, 1);
      run(enc(4'h3, 1, 0, 4'd1, 4'd1, 2'b10, 8'd1), 32'h5000, 32'h0, 0, 1, 0);
      chk("R1 other top bits accepted", cnt_wr, 1);

      // R12 strobe during a double sequence
      run(enc(4'hE, 1, 0, 4'd6, 4'd2, 2'b11, 8'd4), 32'h6000, 32'h0, 0, 1, 1);
      chk("R12 busy strobe reads", cnt_mem, 2);
      chk("R12 busy strobe writes", cnt_wr, 1);
      chk("R12 busy strobe data", last_data, {memf(32'h6014), memf(32'h6010)});

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule